// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block steps a small system between four power states and turns that state into clock enables and power-domain enables. In Active, every domain is clocked. In Idle, the processor clock stops, and so do the memory and bus clocks. The main oscillator and the peripheral clocks keep running, so a peripheral can still raise the interrupt that ends Idle. In Power-down, the main oscillator and every internal clock stop, logic and SRAM stay powered, and the output pins are held. Deep power-down removes core power. The SRAM and the low-speed oscillator remain powered only when their retain bits ask for it, and only a reset leaves this state.

The peripheral clock is a one-cycle enable derived from the processor clock at a ratio of 1, 2 or 4. Each peripheral also has its own enable bit. A wake pulse tells the rest of the system that clocks have come back after Idle or Power-down.

States and transitions:
- ACTIVE to IDLE, PDOWN or DEEP, on a mode request.
- IDLE to ACTIVE, on any enabled interrupt.
- PDOWN to ACTIVE, on an enabled interrupt from a source that can work without a clock.
- DEEP to ACTIVE, only through reset.
- Reset from any state goes to ACTIVE.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the state is Active. The processor, memory, oscillator, core, SRAM, low-speed oscillator and RTC enables are 1, the pin hold and wake are 0, and the peripheral clock runs at one quarter rate: its first pulse appears in the fourth cycle after reset is released.
- R2: In Active, a mode request with code 1 enters Idle. In Idle, the processor and memory enables are 0, while the oscillator, the RTC and the per-peripheral enables stay on.
- R3: Idle returns to Active only when some interrupt line is both high and enabled. A high line whose enable bit is 0 leaves the block in Idle.
- R4: Code 2 enters Power-down. There, the processor, memory, peripheral and peripheral-clock enables are 0 and the main oscillator enable is 0. Core, SRAM and low-speed-oscillator power stay 1, and the pin hold is 1.
- R5: Power-down returns to Active only on a line that is high, enabled and flagged as able to wake without clocks. Enabled lines without that flag, and flagged lines that are not enabled, are ignored.
- R6: The RTC clock select is captured on entry to a low-power state; later changes to it have no effect until the block is back in Active. In Power-down, the RTC enable is 1 only when the low-speed clock was selected. In Deep power-down, it is 1 only when the low-speed clock was selected and that oscillator was retained. In Active and Idle it is 1.
- R7: Code 3 enters Deep power-down. Core power and the oscillator enable are 0, and the pin hold is 1. The SRAM and low-speed-oscillator power enables follow the retain bits as captured on entry. No interrupt leaves this state; only reset does.
- R8: The peripheral-clock ratio code maps 1 to divide-by-1, 2 to divide-by-2, and both 0 and 3 to divide-by-4.
- R9: A new ratio takes effect only when the current divided period ends. The period running when the code changes finishes at the old length.
- R10: In Active and Idle, each peripheral clock enable follows its own enable bit. An enable-bit change shows on that output at the next falling edge.
- R11: Leaving Idle or Power-down raises wake for exactly one cycle. The pulse starts one cycle after the clock enables return.
- R12: A mode request is ignored outside Active. A request with code 0 is ignored in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req_vld | input | 1 | Mode request strobe |
| mode_req_code | input | 2 | Requested mode: 0 none, 1 Idle, 2 Power-down, 3 Deep power-down |
| irq_lvl | input | NIRQ | Interrupt levels |
| irq_en | input | NIRQ | Interrupt enables |
| irq_nclk_ok | input | NIRQ | Line can wake without clocks |
| periph_en | input | NPER | Per-peripheral clock enable bits |
| pclk_div_code | input | 2 | Peripheral clock ratio code |
| rtc_lf_sel | input | 1 | RTC clocked from low-speed clock when 1 |
| sram_retain | input | 1 | Keep SRAM powered in Deep power-down |
| lfosc_retain | input | 1 | Keep low-speed oscillator powered in Deep power-down |
| cpu_clk_en | output | 1 | Processor clock enable |
| mem_clk_en | output | 1 | Memory and bus clock enable |
| periph_clk_en | output | NPER | Per-peripheral clock enables |
| pclk_en | output | 1 | Peripheral clock pulse, one cycle per divided period |
| rtc_clk_en | output | 1 | RTC clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| core_pwr_en | output | 1 | Core logic power enable |
| sram_pwr_en | output | 1 | SRAM power enable |
| lfosc_pwr_en | output | 1 | Low-speed oscillator power enable |
| io_hold | output | 1 | Hold output pin levels |
| wake | output | 1 | One-cycle pulse after clocks return |

## Verification
The assertions assume the following about the inputs:
- Reset is low before the first clock edge.
- Mode request, interrupt and configuration inputs change only between rising edges.
- Interrupt lines are levels that hold until the state has changed.

The stimulus meets these rules by driving every input shortly after a rising edge and holding each interrupt level for at least two cycles. Each transition rule is exercised with lines that are high but only partly qualified. Retain and clock-select inputs are changed while the block is asleep, so that the captured copies are checked against the live inputs.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_IDLE   = 2'd1,
        PM_PDOWN  = 2'd2,
        PM_DEEP   = 2'd3
    } pm_state_e;

    localparam logic [1:0] REQ_STAY  = 2'd0;
    localparam logic [1:0] REQ_IDLE  = 2'd1;
    localparam logic [1:0] REQ_PDOWN = 2'd2;
    localparam logic [1:0] REQ_DEEP  = 2'd3;

    localparam int unsigned DIV_MAX = 4;
    localparam int unsigned DIV_CW  = $clog2(DIV_MAX);
    localparam int unsigned DIV_RW  = DIV_CW + 1;

    typedef struct packed {
        logic cpu;
        logic mem;
        logic osc;
        logic core;
        logic sram;
        logic lfosc;
        logic rtc;
        logic hold;
    } dom_en_t;

    localparam dom_en_t DOM_RESET = '{cpu: 1'b1, mem: 1'b1, osc: 1'b1, core: 1'b1,
                                      sram: 1'b1, lfosc: 1'b1, rtc: 1'b1, hold: 1'b0};

    // Ratio code decode: 1 -> /1, 2 -> /2, 0 and 3 -> /DIV_MAX
    function automatic logic [DIV_RW-1:0] ratio_of(input logic [1:0] code);
        logic [DIV_RW-1:0] r;
        case (code)
            2'b01:   r = DIV_RW'(1);
            2'b10:   r = DIV_RW'(2);
            default: r = DIV_RW'(DIV_MAX);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
    import pcc_pkg::*;
#(
    parameter int unsigned NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_vld,
    input  logic [1:0]      req_code,
    input  logic [NIRQ-1:0] irq_lvl,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_nclk_ok,
    input  logic            rtc_lf_sel,
    input  logic            sram_retain,
    input  logic            lfosc_retain,
    output pm_state_e       state_o,
    output logic            keep_rtc_lf_o,
    output logic            keep_sram_o,
    output logic            keep_lfosc_o,
    output logic            wake_o
);

    pm_state_e state_q, state_d;
    logic      idle_wake, pd_wake;
    logic      enter_lp, leave_lp;
    logic      leave_q, wake_q;
    logic      keep_rtc_q, keep_sram_q, keep_lf_q;

    assign idle_wake = |(irq_lvl & irq_en);
    assign pd_wake   = |(irq_lvl & irq_en & irq_nclk_ok);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_ACTIVE: begin
                if (req_vld) begin
                    case (req_code)
                        REQ_IDLE:  state_d = PM_IDLE;
                        REQ_PDOWN: state_d = PM_PDOWN;
                        REQ_DEEP:  state_d = PM_DEEP;
                        default:   state_d = PM_ACTIVE;
                    endcase
                end
            end
            PM_IDLE:  if (idle_wake) state_d = PM_ACTIVE;
            PM_PDOWN: if (pd_wake)   state_d = PM_ACTIVE;
            PM_DEEP:  state_d = PM_DEEP;
        endcase
    end

    assign enter_lp = (state_q == PM_ACTIVE) && (state_d != PM_ACTIVE);
    assign leave_lp = (state_q != PM_ACTIVE) && (state_d == PM_ACTIVE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_ACTIVE;
        else        state_q <= state_d;
    end

    // Registered outputs: retention snapshot and wake pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_rtc_q  <= 1'b0;
            keep_sram_q <= 1'b1;
            keep_lf_q   <= 1'b1;
            leave_q     <= 1'b0;
            wake_q      <= 1'b0;
        end else begin
            if (enter_lp) begin
                keep_rtc_q  <= rtc_lf_sel;
                keep_sram_q <= sram_retain;
                keep_lf_q   <= lfosc_retain;
            end
            leave_q <= leave_lp;
            wake_q  <= leave_q;
        end
    end

    assign state_o       = state_q;
    assign keep_rtc_lf_o = keep_rtc_q;
    assign keep_sram_o   = keep_sram_q;
    assign keep_lfosc_o  = keep_lf_q;
    assign wake_o        = wake_q;

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == PM_ACTIVE && req_vld && req_code == REQ_IDLE) |=> (state_q == PM_IDLE)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == PM_IDLE && (irq_lvl & irq_en) == '0) |=> (state_q == PM_IDLE)); // R3
    AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == PM_PDOWN && (irq_lvl & irq_en & irq_nclk_ok) == '0) |=> (state_q == PM_PDOWN)); // R5
    AST_DEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == PM_DEEP) |=> (state_q == PM_DEEP)); // R7
    AST_STAY_REQ: assert property (@(posedge clk) disable iff (!rst_n) (state_q == PM_ACTIVE && (!req_vld || req_code == REQ_STAY)) |=> (state_q == PM_ACTIVE)); // R12

endmodule

// File: rtl/pcc_pclk_div.sv
module pcc_pclk_div
    import pcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_code,
    output logic       tick_o
);

    logic [DIV_CW-1:0] cnt_q;
    logic [DIV_RW-1:0] ratio_q;
    logic              at_end;

    assign at_end = ({1'b0, cnt_q} == (ratio_q - DIV_RW'(1)));
    assign tick_o = run && at_end;

    // The ratio register reloads only at the end of a divided period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= DIV_RW'(DIV_MAX);
        end else if (run) begin
            if (at_end) begin
                cnt_q   <= '0;
                ratio_q <= ratio_of(div_code);
            end else begin
                cnt_q <= cnt_q + DIV_CW'(1);
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ({1'b0, cnt_q} < ratio_q)); // R8
    AST_RATIO_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) !tick_o |=> $stable(ratio_q)); // R9

endmodule

// File: rtl/pcc_clk_gate.sv
module pcc_clk_gate
    import pcc_pkg::*;
#(
    parameter int unsigned NPER = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pm_state_e       state_i,
    input  logic [NPER-1:0] periph_en_i,
    input  logic            pclk_tick_i,
    input  logic            keep_rtc_lf_i,
    input  logic            keep_sram_i,
    input  logic            keep_lfosc_i,
    output dom_en_t         dom_o,
    output logic [NPER-1:0] per_o,
    output logic            pclk_o
);

    dom_en_t         dom_d, dom_q;
    logic [NPER-1:0] per_d, per_q;
    logic            pclk_d, pclk_q;

    always_comb begin
        dom_d  = DOM_RESET;
        per_d  = '0;
        pclk_d = 1'b0;
        unique case (state_i)
            PM_ACTIVE: begin
                per_d  = periph_en_i;
                pclk_d = pclk_tick_i;
            end
            PM_IDLE: begin
                dom_d.cpu = 1'b0;
                dom_d.mem = 1'b0;
                per_d     = periph_en_i;
                pclk_d    = pclk_tick_i;
            end
            PM_PDOWN: begin
                dom_d.cpu  = 1'b0;
                dom_d.mem  = 1'b0;
                dom_d.osc  = 1'b0;
                dom_d.rtc  = keep_rtc_lf_i;
                dom_d.hold = 1'b1;
            end
            PM_DEEP: begin
                dom_d.cpu   = 1'b0;
                dom_d.mem   = 1'b0;
                dom_d.osc   = 1'b0;
                dom_d.core  = 1'b0;
                dom_d.sram  = keep_sram_i;
                dom_d.lfosc = keep_lfosc_i;
                dom_d.rtc   = keep_rtc_lf_i && keep_lfosc_i;
                dom_d.hold  = 1'b1;
            end
        endcase
    end

    // Enables change only while the source clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_q  <= DOM_RESET;
            per_q  <= '0;
            pclk_q <= 1'b0;
        end else begin
            dom_q  <= dom_d;
            per_q  <= per_d;
            pclk_q <= pclk_d;
        end
    end

    assign dom_o  = dom_q;
    assign per_o  = per_q;
    assign pclk_o = pclk_q;

    AST_PD_PERIPH_OFF: assert property (@(posedge clk) disable iff (!rst_n) (state_i == PM_PDOWN && $past(state_i) == PM_PDOWN) |-> (per_q == '0 && !pclk_q)); // R4
    AST_DEEP_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n) (state_i == PM_DEEP && $past(state_i) == PM_DEEP) |-> (!dom_q.core && dom_q.hold)); // R7

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
    import pcc_pkg::*;
#(
    parameter int unsigned NIRQ = 4,
    parameter int unsigned NPER = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_req_vld,
    input  logic [1:0]      mode_req_code,
    input  logic [NIRQ-1:0] irq_lvl,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_nclk_ok,
    input  logic [NPER-1:0] periph_en,
    input  logic [1:0]      pclk_div_code,
    input  logic            rtc_lf_sel,
    input  logic            sram_retain,
    input  logic            lfosc_retain,
    output logic            cpu_clk_en,
    output logic            mem_clk_en,
    output logic [NPER-1:0] periph_clk_en,
    output logic            pclk_en,
    output logic            rtc_clk_en,
    output logic            main_osc_en,
    output logic            core_pwr_en,
    output logic            sram_pwr_en,
    output logic            lfosc_pwr_en,
    output logic            io_hold,
    output logic            wake
);

    pm_state_e state;
    logic      keep_rtc, keep_sram, keep_lf;
    logic      div_run, div_tick;
    dom_en_t   dom;

    pcc_mode_fsm #(.NIRQ(NIRQ)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_vld       (mode_req_vld),
        .req_code      (mode_req_code),
        .irq_lvl       (irq_lvl),
        .irq_en        (irq_en),
        .irq_nclk_ok   (irq_nclk_ok),
        .rtc_lf_sel    (rtc_lf_sel),
        .sram_retain   (sram_retain),
        .lfosc_retain  (lfosc_retain),
        .state_o       (state),
        .keep_rtc_lf_o (keep_rtc),
        .keep_sram_o   (keep_sram),
        .keep_lfosc_o  (keep_lf),
        .wake_o        (wake)
    );

    assign div_run = (state == PM_ACTIVE) || (state == PM_IDLE);

    pcc_pclk_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (div_run),
        .div_code (pclk_div_code),
        .tick_o   (div_tick)
    );

    pcc_clk_gate #(.NPER(NPER)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .periph_en_i   (periph_en),
        .pclk_tick_i   (div_tick),
        .keep_rtc_lf_i (keep_rtc),
        .keep_sram_i   (keep_sram),
        .keep_lfosc_i  (keep_lf),
        .dom_o         (dom),
        .per_o         (periph_clk_en),
        .pclk_o        (pclk_en)
    );

    assign cpu_clk_en   = dom.cpu;
    assign mem_clk_en   = dom.mem;
    assign main_osc_en  = dom.osc;
    assign core_pwr_en  = dom.core;
    assign sram_pwr_en  = dom.sram;
    assign lfosc_pwr_en = dom.lfosc;
    assign rtc_clk_en   = dom.rtc;
    assign io_hold      = dom.hold;

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wake |=> !wake); // R11
    AST_WAKE_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n) wake |-> (cpu_clk_en && mem_clk_en && main_osc_en)); // R11
    AST_PD_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n) (state == PM_PDOWN && $past(state) == PM_PDOWN) |-> (!main_osc_en && !cpu_clk_en && core_pwr_en && io_hold)); // R4

endmodule

// File: tb/pwr_clk_ctrl_bench.sv
module pwr_clk_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int NIRQ       = 4;
    localparam int NPER       = 4;
    localparam logic [13:0] MASK_ALL  = 14'h3FFF;
    localparam logic [13:0] MASK_NOPC = 14'h3F7F;
    localparam logic [13:0] PC_BIT    = 14'h0080;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_req_vld = 1'b0;
    logic [1:0]      mode_req_code = 2'd0;
    logic [NIRQ-1:0] irq_lvl = '0;
    logic [NIRQ-1:0] irq_en = '0;
    logic [NIRQ-1:0] irq_nclk_ok = '0;
    logic [NPER-1:0] periph_en = '0;
    logic [1:0]      pclk_div_code = 2'd0;
    logic            rtc_lf_sel = 1'b0;
    logic            sram_retain = 1'b1;
    logic            lfosc_retain = 1'b1;
    logic            cpu_clk_en, mem_clk_en, pclk_en, rtc_clk_en, main_osc_en;
    logic            core_pwr_en, sram_pwr_en, lfosc_pwr_en, io_hold, wake;
    logic [NPER-1:0] periph_clk_en;
    logic [13:0]     got;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [13:0] exp_q[$];
    logic [13:0] msk_q[$];
    string       tag_q[$];

    always #(HALF) clk = ~clk;

    pwr_clk_ctrl #(.NIRQ(NIRQ), .NPER(NPER)) u_pwr_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req_code(mode_req_code),
        .irq_lvl(irq_lvl), .irq_en(irq_en), .irq_nclk_ok(irq_nclk_ok), .periph_en(periph_en),
        .pclk_div_code(pclk_div_code), .rtc_lf_sel(rtc_lf_sel), .sram_retain(sram_retain),
        .lfosc_retain(lfosc_retain), .cpu_clk_en(cpu_clk_en), .mem_clk_en(mem_clk_en),
        .periph_clk_en(periph_clk_en), .pclk_en(pclk_en), .rtc_clk_en(rtc_clk_en),
        .main_osc_en(main_osc_en), .core_pwr_en(core_pwr_en), .sram_pwr_en(sram_pwr_en),
        .lfosc_pwr_en(lfosc_pwr_en), .io_hold(io_hold), .wake(wake)
    );

    assign got = {cpu_clk_en, mem_clk_en, periph_clk_en, pclk_en, rtc_clk_en, main_osc_en,
                  core_pwr_en, sram_pwr_en, lfosc_pwr_en, io_hold, wake};

    function automatic logic [13:0] ev(input logic cpu, input logic mem, input logic [3:0] per,
                                       input logic pc, input logic rtc, input logic osc,
                                       input logic core, input logic sram, input logic lf,
                                       input logic hold, input logic wk);
        return {cpu, mem, per, pc, rtc, osc, core, sram, lf, hold, wk};
    endfunction

    function automatic logic [13:0] act(input logic [3:0] per);
        return ev(1, 1, per, 0, 1, 1, 1, 1, 1, 0, 0);
    endfunction
    function automatic logic [13:0] idl(input logic [3:0] per);
        return ev(0, 0, per, 0, 1, 1, 1, 1, 1, 0, 0);
    endfunction
    function automatic logic [13:0] pdn(input logic rtc);
        return ev(0, 0, 4'b0000, 0, rtc, 0, 1, 1, 1, 1, 0);
    endfunction
    function automatic logic [13:0] dpd(input logic sram, input logic lf, input logic rtc);
        return ev(0, 0, 4'b0000, 0, rtc, 0, 0, sram, lf, 1, 0);
    endfunction

    // Driver: queue the value expected just before the next rising edge
    task automatic step(input logic [13:0] e, input logic [13:0] m, input string t);
        exp_q.push_back(e);
        msk_q.push_back(m);
        tag_q.push_back(t);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Monitor: sample one time unit before each rising edge
    initial begin
        logic [13:0] e, m;
        string t;
        forever begin
            @(negedge clk);
            #(HALF - 1);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                m = msk_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ((got & m) !== (e & m)) begin
                    errors++;
                    $display("FAIL %s: got %b expected %b (mask %b)", t, got & m, e & m, m);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [17:0] pat;
        string t;
        pat = 18'b010001010101111000;
        periph_en = 4'b1010;
        do_reset();

        // R1 / R8 / R9: reset state and divider ratio sequence
        for (int k = 0; k < 18; k++) begin
            if (k == 0)  pclk_div_code = 2'b01;
            if (k == 6)  pclk_div_code = 2'b10;
            if (k == 11) pclk_div_code = 2'b11;
            if (k == 0)      t = "R1 reset state";
            else if (k < 4)  t = "R1 quarter rate after reset";
            else if (k < 7)  t = "R9 boundary, R8 code 01";
            else if (k < 13) t = "R8 code 10";
            else             t = "R8 code 11 reserved";
            step(act(4'b1010) | (pat[k] ? PC_BIT : 14'h0), MASK_ALL, t);
        end

        // Idle entry, gating, exit and wake
        periph_en = 4'b0110;
        step(act(4'b0110), MASK_NOPC, "R10 active gating");
        mode_req_vld = 1'b1; mode_req_code = 2'd1;
        step(act(4'b0110), MASK_NOPC, "R2 before idle");
        mode_req_vld = 1'b0;
        step(idl(4'b0110), MASK_NOPC, "R2 idle entered");
        periph_en = 4'b0011;
        step(idl(4'b0011), MASK_NOPC, "R10 idle gating");
        irq_lvl = 4'b0001; irq_en = 4'b0000;
        mode_req_vld = 1'b1; mode_req_code = 2'd3;
        step(idl(4'b0011), MASK_NOPC, "R3 idle hold");
        mode_req_vld = 1'b0;
        step(idl(4'b0011), MASK_NOPC, "R3 disabled irq ignored, R12 request in idle");
        irq_en = 4'b0001;
        step(idl(4'b0011), MASK_NOPC, "R3 idle before exit");
        step(act(4'b0011), MASK_NOPC, "R3 idle exit");
        irq_lvl = 4'b0000;
        step(act(4'b0011) | 14'h1, MASK_NOPC, "R11 wake pulse");
        step(act(4'b0011), MASK_NOPC, "R11 wake single cycle");
        mode_req_vld = 1'b1; mode_req_code = 2'd0;
        step(act(4'b0011), MASK_NOPC, "R12 code 0");
        mode_req_vld = 1'b0;
        step(act(4'b0011), MASK_NOPC, "R12 code 0 ignored");
        step(act(4'b0011), MASK_NOPC, "R12 still active");

        // Power-down with low-speed RTC
        rtc_lf_sel = 1'b1; irq_en = 4'b0011; irq_nclk_ok = 4'b0010; periph_en = 4'b1111;
        mode_req_vld = 1'b1; mode_req_code = 2'd2;
        step(act(4'b1111), MASK_NOPC, "R4 before power-down");
        mode_req_vld = 1'b0;
        step(pdn(1'b1), MASK_NOPC, "R4 power-down outputs, R6 rtc kept");
        rtc_lf_sel = 1'b0; irq_lvl = 4'b0001;
        step(pdn(1'b1), MASK_NOPC, "R6 select change ignored");
        step(pdn(1'b1), MASK_NOPC, "R5 clocked irq ignored");
        irq_nclk_ok = 4'b0110; irq_lvl = 4'b0100;
        step(pdn(1'b1), MASK_NOPC, "R5 hold");
        step(pdn(1'b1), MASK_NOPC, "R5 disabled clockless irq ignored");
        irq_lvl = 4'b0010;
        step(pdn(1'b1), MASK_NOPC, "R5 before exit");
        step(act(4'b1111), MASK_NOPC, "R5 power-down exit");
        irq_lvl = 4'b0000;
        step(act(4'b1111) | 14'h1, MASK_NOPC, "R11 wake after power-down");
        step(act(4'b1111), MASK_NOPC, "R11 wake cleared");

        // Power-down with RTC on the peripheral clock
        mode_req_vld = 1'b1; mode_req_code = 2'd2;
        step(act(4'b1111), MASK_NOPC, "R6 before power-down");
        mode_req_vld = 1'b0;
        step(pdn(1'b0), MASK_NOPC, "R6 rtc stopped");
        irq_lvl = 4'b0010;
        step(pdn(1'b0), MASK_NOPC, "R6 hold");
        step(act(4'b1111), MASK_NOPC, "R5 exit again");
        irq_lvl = 4'b0000;
        step(act(4'b1111) | 14'h1, MASK_NOPC, "R11 second wake");

        // Deep power-down, SRAM kept, low-speed oscillator dropped
        rtc_lf_sel = 1'b1; sram_retain = 1'b1; lfosc_retain = 1'b0;
        mode_req_vld = 1'b1; mode_req_code = 2'd3;
        step(act(4'b1111), MASK_NOPC, "R7 before deep");
        mode_req_vld = 1'b0;
        step(dpd(1'b1, 1'b0, 1'b0), MASK_NOPC, "R7 deep outputs");
        irq_lvl = 4'b0010; sram_retain = 1'b0;
        for (int k = 0; k < 4; k++)
            step(dpd(1'b1, 1'b0, 1'b0), MASK_NOPC, "R7 no irq exit, retain captured");
        irq_lvl = 4'b0000;

        // Reset leaves deep; second deep with the other retain choice
        lfosc_retain = 1'b1;
        do_reset();
        mode_req_vld = 1'b1; mode_req_code = 2'd3;
        step(act(4'b1111), MASK_NOPC, "R7 reset exit, R1 state");
        mode_req_vld = 1'b0;
        step(dpd(1'b0, 1'b1, 1'b1), MASK_NOPC, "R6 rtc in deep, R7 retain");
        step(dpd(1'b0, 1'b1, 1'b1), MASK_NOPC, "R7 deep hold");

        #(CLK_PERIOD);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule